// File: doc/BRIEF.md
# Iterative AES-128 Key Schedule Generator

This block turns a 128-bit cipher key into the complete AES-128 key schedule: eleven 128-bit round keys, 1408 bits in total. Expansion is serial. A small sequencer that starts from reset produces one new 32-bit word on each clock. The block holds four forward S-boxes for the word substitution. Each S-box is computed as the GF(2^8) inverse followed by the affine transform, so no stored table is needed.

Release the active-low reset and hold the key on `key_i` for the first rising edge. Forty-one edges later `done_o` rises and `sched_o` carries the whole schedule. The schedule then stays frozen until reset is asserted again, which restarts expansion with whatever key is present. The schedule is the same for encryption and decryption. Picking out round keys, and ordering them for decryption, is left to the block that consumes `sched_o`.

Top module: `aes_key_expander`

## Requirements
- R1: While `rst_ni` is low, `done_o` is 0 and `sched_o` is all zeros.
- R2: `key_i` is captured only on the first rising edge after `rst_ni` goes high. Round key 0 equals that key. Later changes on `key_i` have no effect on `sched_o`.
- R3: For each word index i from 4 to 43 where i is not a multiple of 4, word i = word i-4 XOR word i-1.
- R4: For each word index i that is a multiple of 4, word i = word i-4 XOR SubWord(RotWord(word i-1)) XOR (Rcon << 24). RotWord moves the most significant byte to the least significant position.
- R5: Rcon steps through 01,02,04,08,10,20,40,80,1B,36, one value per group of four words, starting at word 4.
- R6: SubWord applies to each byte the GF(2^8) multiplicative inverse modulo 0x11B, with 0 mapped to 0, followed by the AES affine transform with constant 0x63.
- R7: `done_o` is 0 after the 40th rising edge following reset release and is 1 after the 41st.
- R8: Once `done_o` is 1, it and `sched_o` hold their values until the next reset.
- R9: Asserting reset at any time, including in the middle of an expansion, discards the current schedule and recomputes it from the key present after release.
- R10: Word w occupies `sched_o[1407-32*w -: 32]`, and round key r occupies `sched_o[1407-128*r -: 128]`. Within a word, key byte 0 is the most significant byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its release starts an expansion |
| key_i | input | 128 | Cipher key, byte 0 in bits 127:120 |
| sched_o | output | 1408 | Expanded key, word 0 in the top 32 bits |
| done_o | output | 1 | Schedule complete and stable |

## Verification
The first rising edge after reset release loads the key. Edges 2 through 41 each append one word, so the last word and `done_o` appear together after edge 41 and nothing is valid earlier. The bench releases reset on a falling edge, counts falling edges from there, and reads `done_o` after edge 40, where it must still be low, and after edge 41, where it must be high. It samples the schedule only after edge 41. Reset, key changes and the mid-expansion restart are also driven on falling edges, so every read lands half a cycle after the edge it depends on.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;
  parameter int unsigned KEY_W   = 128;
  parameter int unsigned WORD_W  = 32;
  parameter int unsigned N_ROUND = 10;
  localparam int unsigned NK      = KEY_W / WORD_W;
  localparam int unsigned N_WORDS = NK * (N_ROUND + 1);
  localparam int unsigned SCHED_W = N_WORDS * WORD_W;
  localparam int unsigned N_STEPS = N_WORDS - NK;
  localparam int unsigned CNT_W   = $clog2(N_STEPS + 1);
  localparam int unsigned PH_W    = (NK > 1) ? $clog2(NK) : 1;
  localparam int unsigned DONE_EDGE = N_STEPS + 1;

  typedef enum logic [1:0] {ST_LOAD, ST_RUN, ST_DONE} kx_state_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ p;
      p = gf_xtime(p);
    end
    return acc;
  endfunction

  // a^254 == a^-1 in GF(2^8); 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p, r;
    p = a;
    r = 8'h01;
    for (int k = 1; k < 8; k++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_kx_sbox.sv
module aes_kx_sbox (
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  import aes_kx_pkg::*;
  always_comb byte_o = sbox_fwd(byte_i);
endmodule

// File: rtl/aes_kx_subrot.sv
module aes_kx_subrot
  import aes_kx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [7:0]        rcon_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned NB = WORD_W / 8;

  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] sub_w;

  assign rot_w = {word_i[WORD_W-9:0], word_i[WORD_W-1 -: 8]};

  for (genvar b = 0; b < NB; b++) begin : g_sbox
    aes_kx_sbox u_sbox (
      .byte_i(rot_w[8*b +: 8]),
      .byte_o(sub_w[8*b +: 8])
    );
  end

  assign word_o = sub_w ^ {rcon_i, {(WORD_W-8){1'b0}}};
endmodule

// File: rtl/aes_kx_ctrl.sv
module aes_kx_ctrl
  import aes_kx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       load_o,
  output logic       step_o,
  output logic       mix_o,
  output logic [7:0] rcon_o,
  output logic       done_o
);
  kx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic [7:0]       rcon_q;

  assign load_o = (state_q == ST_LOAD);
  assign step_o = (state_q == ST_RUN);
  assign mix_o  = step_o && (ph_q == '0);
  assign rcon_o = rcon_q;
  assign done_o = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      ph_q    <= '0;
      rcon_q  <= 8'h01;
    end else begin
      case (state_q)
        ST_LOAD: state_q <= ST_RUN;
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          ph_q  <= (ph_q == PH_W'(NK - 1)) ? '0 : ph_q + 1'b1;
          if (mix_o) rcon_q <= gf_xtime(rcon_q);
          if (cnt_q == CNT_W'(N_STEPS - 1)) state_q <= ST_DONE;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander
  import aes_kx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [KEY_W-1:0]   key_i,
  output logic [SCHED_W-1:0] sched_o,
  output logic               done_o
);
  logic              load_en, step_en, mix_en;
  logic [7:0]        rcon;
  logic [SCHED_W-1:0] sched_q;
  logic [WORD_W-1:0] w_prev, w_back, w_sub, w_new;

  aes_kx_ctrl u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_o(load_en),
    .step_o(step_en),
    .mix_o (mix_en),
    .rcon_o(rcon),
    .done_o(done_o)
  );

  // newest word sits at the bottom; word i-NK at a fixed offset
  assign w_prev = sched_q[WORD_W-1:0];
  assign w_back = sched_q[NK*WORD_W-1 -: WORD_W];

  aes_kx_subrot u_subrot (
    .word_i(w_prev),
    .rcon_i(rcon),
    .word_o(w_sub)
  );

  assign w_new = w_back ^ (mix_en ? w_sub : w_prev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sched_q <= '0;
    else if (load_en) sched_q <= {{(SCHED_W-KEY_W){1'b0}}, key_i};
    else if (step_en) sched_q <= {sched_q[SCHED_W-WORD_W-1:0], w_new};
  end

  assign sched_o = sched_q;
endmodule

// File: rtl/aes_kx_chk.sv
module aes_kx_chk
  import aes_kx_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [KEY_W-1:0]   key_i,
  input logic [SCHED_W-1:0] sched_o,
  input logic               done_o,
  input logic               load_en,
  input logic               step_en,
  input logic               mix_en
);
  logic [6:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != '1)   cyc_q <= cyc_q + 1'b1;
  end

  AST_LOAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> sched_o[KEY_W-1:0] == $past(key_i)); // R2
  AST_PLAIN_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en && !mix_en) |=> sched_o[WORD_W-1:0] ==
      ($past(sched_o[WORD_W-1:0]) ^ $past(sched_o[NK*WORD_W-1 -: WORD_W]))); // R3
  AST_DONE_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cyc_q == 7'(DONE_EDGE)); // R7
  AST_DONE_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < 7'(DONE_EDGE)) |-> !done_o); // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R8
  AST_SCHED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(sched_o)); // R8
  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_en, step_en, done_o})); // R9
endmodule

bind aes_key_expander aes_kx_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .key_i  (key_i),
  .sched_o(sched_o),
  .done_o (done_o),
  .load_en(load_en),
  .step_en(step_en),
  .mix_en (mix_en)
);

// File: tb/aes_key_expander_tb.sv
`timescale 1ns/1ps
module aes_key_expander_tb;
  import aes_kx_pkg::*;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [KEY_W-1:0]   key_i = '0;
  logic [SCHED_W-1:0] sched_o;
  logic               done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  aes_key_expander u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .key_i  (key_i),
    .sched_o(sched_o),
    .done_o (done_o)
  );

  // {key, round key 1, round key 10}
  localparam int NV = 3;
  localparam logic [383:0] VECS [NV] = '{
    {128'h2b7e151628aed2a6abf7158809cf4f3c,
     128'ha0fafe1788542cb123a339392a6c7605,
     128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
    {128'h000102030405060708090a0b0c0d0e0f,
     128'hd6aa74fdd2af72fadaa678f1d6ab76fe,
     128'h13111d7fe3944a17f307a78b4d2b30c5},
    {128'h00000000000000000000000000000000,
     128'h62636363626363636263636362636363,
     128'hb4ef5bcb3e92e21123e951cf6f8f188e}
  };

  function automatic logic [127:0] rk(input int r);
    return sched_o[SCHED_W-1-128*r -: 128];
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // reset, release, load key; leaves time just after edge 40 (0-based)
  task automatic expand(input logic [127:0] key, input string tag);
    @(negedge clk_i);
    rst_ni = 1'b0;
    key_i  = key;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk_i);
    chk({tag, " R7 done low after 40 edges"}, {127'd0, done_o}, 128'd0);
    @(negedge clk_i);
    chk({tag, " R7 done high after 41 edges"}, {127'd0, done_o}, 128'd1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    // R1: reset state held across clocks
    key_i = VECS[0][383:256];
    repeat (3) @(negedge clk_i);
    chk("R1 done in reset", {127'd0, done_o}, 128'd0);
    chk("R1 sched in reset", sched_o[127:0], 128'd0);
    chk("R1 sched top in reset", rk(0), 128'd0);

    for (int v = 0; v < NV; v++) begin
      expand(VECS[v][383:256], "vec");
      chk("R2 R10 round key 0", rk(0), VECS[v][383:256]);
      chk("R4 R6 round key 1", rk(1), VECS[v][255:128]);
      chk("R3 R5 round key 10", rk(10), VECS[v][127:0]);
    end

    // R8 / R2: hold after done, key changes ignored
    begin
      logic [127:0] last;
      last = rk(10);
      key_i = ~key_i;
      repeat (12) @(negedge clk_i);
      chk("R8 done sticky", {127'd0, done_o}, 128'd1);
      chk("R2 key change ignored rk0", rk(0), VECS[NV-1][383:256]);
      chk("R8 rk10 stable", rk(10), last);
    end

    // R2: key changes right after the load edge are ignored
    @(negedge clk_i);
    rst_ni = 1'b0;
    key_i  = VECS[0][383:256];
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    key_i = VECS[1][383:256];
    repeat (40) @(negedge clk_i);
    chk("R2 late key ignored rk10", rk(10), VECS[0][127:0]);

    // R9: restart mid-expansion with another key
    @(negedge clk_i);
    rst_ni = 1'b0;
    key_i  = VECS[0][383:256];
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R9 not done mid-run", {127'd0, done_o}, 128'd0);
    expand(VECS[1][383:256], "R9 restart");
    chk("R9 restart rk0", rk(0), VECS[1][383:256]);
    chk("R9 restart rk10", rk(10), VECS[1][127:0]);

    // R1: reset after done clears outputs
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 done cleared", {127'd0, done_o}, 128'd0);
    chk("R1 sched cleared", rk(10), 128'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule